// File: doc/BRIEF.md
# Built-in Self-Test Sequencer with Run-Time Guard

This block orders a two-phase built-in self-test: a logic test first, then a memory test. A start pulse opens the run. Each phase is handed to an external test engine through a request level and a one-cycle done pulse. The engine reports pass or fail together with its done pulse. A guard counter of its own bounds the time the whole run may take. The chip's general-purpose watchdog cannot do this job, because that watchdog is one of the circuits under test and does not work during the run.

Three groups of flags are kept apart. End flags say that a phase really completed. Result flags say whether a completed phase failed. Error flags record a guard expiry and a summary failure. Every run finishes with a fixed-length reset request, whatever its outcome. Software must read the flags, which survive that reset, and must not treat the reset on its own as a pass. The flags are cleared only by an explicit clear pulse.

All pins are plain control and status levels or pulses. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `selftest_seq`

## Requirements
- R1: A start pulse while idle raises the logic-phase request (`logic_req_o`) and `busy_o` in the next cycle. The memory-phase request stays low.
- R2: A logic done pulse accepted during the logic phase sets `logic_end_o`. In the next cycle the logic request is low and the memory request is high. The memory phase never starts without a completed logic phase.
- R3: A memory done pulse accepted during the memory phase sets `mem_end_o`. `reset_req_o` rises in the next cycle.
- R4: The fail input sampled with an accepted done pulse is stored in that phase's result flag (`logic_bad_o`, `mem_bad_o`). `any_fail_o` is set by any stored fail or by a guard expiry. A completed phase with its fail input low leaves all three flags at 0.
- R5: A nonzero guard value N is captured at start. If the run has not completed after N cycles with a request high, the active request drops and `reset_req_o` rises. `guard_to_o` and `any_fail_o` are set. A done pulse in that last (Nth) cycle is discarded.
- R6: After a guard expiry, any phase that did not complete keeps its end flag at 0. A phase that completed earlier keeps its end flag at 1.
- R7: A guard value of 0 means no time limit: the guard never expires.
- R8: `reset_req_o` is high for exactly RST_CYCLES (default 4) consecutive cycles after every run, passed, failed or expired. Then `busy_o` returns low.
- R9: A start pulse while busy is ignored. No second run follows.
- R10: End, result and error flags keep their values through the reset request and while idle. A `clear_i` pulse sets them all to 0 in the next cycle.
- R11: Done pulses arriving while the matching request is low have no effect on any flag or on the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a self-test run |
| clear_i | input | 1 | Software clear of all flags |
| guard_load_i | input | GUARD_W | Guard limit in request cycles, 0 = unlimited |
| logic_done_i | input | 1 | Logic engine finished |
| logic_fail_i | input | 1 | Logic engine result, valid with done |
| mem_done_i | input | 1 | Memory engine finished |
| mem_fail_i | input | 1 | Memory engine result, valid with done |
| logic_req_o | output | 1 | Logic engine run request |
| mem_req_o | output | 1 | Memory engine run request |
| busy_o | output | 1 | Run or reset request in progress |
| logic_end_o | output | 1 | Logic phase completed |
| mem_end_o | output | 1 | Memory phase completed |
| logic_bad_o | output | 1 | Logic phase reported fail |
| mem_bad_o | output | 1 | Memory phase reported fail |
| guard_to_o | output | 1 | Guard expired during the run |
| any_fail_o | output | 1 | Summary failure flag |
| reset_req_o | output | 1 | End-of-run reset request |

## Verification
The hardest case to reach is a guard expiry after the logic phase has already completed, with a done pulse landing exactly in the expiry cycle. The bench models both engines with tasks that hold off their done pulse for a chosen number of request cycles. It loads a guard value just large enough to pass the logic phase and puts the memory done pulse on the Nth request cycle. A second test puts the logic done pulse on the expiry cycle, so the end flag must stay 0 even though the engine reported completion.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOGIC = 2'd1,
    PH_MEM   = 2'd2,
    PH_RESET = 2'd3
  } phase_t;

  typedef struct packed {
    logic logic_fin;
    logic logic_bad;
    logic mem_fin;
    logic mem_bad;
    logic expired;
  } run_evt_t;
endpackage

// File: rtl/selftest_guard.sv
module selftest_guard #(
  parameter int GUARD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [GUARD_W-1:0] load_val_i,
  input  logic               run_i,
  output logic               limit_en_o,
  output logic               expire_o
);
  localparam logic [GUARD_W-1:0] ONE = GUARD_W'(1);

  logic [GUARD_W-1:0] cnt_q;
  logic               en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      en_q  <= (load_val_i != '0);
    end else if (run_i && en_q && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // expires in the last allowed request cycle
  assign expire_o   = run_i && en_q && (cnt_q == ONE);
  assign limit_en_o = en_q;
endmodule

// File: rtl/selftest_fsm.sv
module selftest_fsm
  import selftest_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     logic_done_i,
  input  logic     logic_fail_i,
  input  logic     mem_done_i,
  input  logic     mem_fail_i,
  input  logic     expire_i,
  output logic     load_o,
  output logic     run_o,
  output phase_t   phase_o,
  output run_evt_t evt_o
);
  localparam int RC_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_CYCLES - 1);

  phase_t          ph_q, ph_d;
  logic [RC_W-1:0] rc_q;

  always_comb begin
    evt_o           = '0;
    evt_o.expired   = expire_i;
    evt_o.logic_fin = (ph_q == PH_LOGIC) && logic_done_i && !expire_i;
    evt_o.logic_bad = evt_o.logic_fin && logic_fail_i;
    evt_o.mem_fin   = (ph_q == PH_MEM) && mem_done_i && !expire_i;
    evt_o.mem_bad   = evt_o.mem_fin && mem_fail_i;
  end

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (start_i) ph_d = PH_LOGIC;
      PH_LOGIC: if (expire_i) ph_d = PH_RESET;
                else if (evt_o.logic_fin) ph_d = PH_MEM;
      PH_MEM:   if (expire_i || evt_o.mem_fin) ph_d = PH_RESET;
      PH_RESET: if (rc_q == RC_LAST) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      rc_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_RESET) rc_q <= rc_q + RC_W'(1);
      else                  rc_q <= '0;
    end
  end

  assign load_o  = (ph_q == PH_IDLE) && start_i;
  assign run_o   = (ph_q == PH_LOGIC) || (ph_q == PH_MEM);
  assign phase_o = ph_q;
endmodule

// File: rtl/selftest_flags.sv
module selftest_flags
  import selftest_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear_i,
  input  run_evt_t evt_i,
  output logic     logic_end_o,
  output logic     mem_end_o,
  output logic     logic_bad_o,
  output logic     mem_bad_o,
  output logic     guard_to_o,
  output logic     any_fail_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      logic_end_o <= 1'b0;
      mem_end_o   <= 1'b0;
      logic_bad_o <= 1'b0;
      mem_bad_o   <= 1'b0;
      guard_to_o  <= 1'b0;
      any_fail_o  <= 1'b0;
    end else begin
      if (clear_i) begin
        logic_end_o <= 1'b0;
        mem_end_o   <= 1'b0;
        logic_bad_o <= 1'b0;
        mem_bad_o   <= 1'b0;
        guard_to_o  <= 1'b0;
        any_fail_o  <= 1'b0;
      end
      // a new event in the same cycle outranks the clear
      if (evt_i.logic_fin) logic_end_o <= 1'b1;
      if (evt_i.mem_fin)   mem_end_o   <= 1'b1;
      if (evt_i.logic_bad) logic_bad_o <= 1'b1;
      if (evt_i.mem_bad)   mem_bad_o   <= 1'b1;
      if (evt_i.expired)   guard_to_o  <= 1'b1;
      if (evt_i.expired || evt_i.logic_bad || evt_i.mem_bad) any_fail_o <= 1'b1;
    end
  end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int GUARD_W    = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               clear_i,
  input  logic [GUARD_W-1:0] guard_load_i,
  input  logic               logic_done_i,
  input  logic               logic_fail_i,
  input  logic               mem_done_i,
  input  logic               mem_fail_i,
  output logic               logic_req_o,
  output logic               mem_req_o,
  output logic               busy_o,
  output logic               logic_end_o,
  output logic               mem_end_o,
  output logic               logic_bad_o,
  output logic               mem_bad_o,
  output logic               guard_to_o,
  output logic               any_fail_o,
  output logic               reset_req_o
);
  phase_t   phase;
  run_evt_t evt;
  logic     load, run, expire, limit_en;

  selftest_guard #(.GUARD_W(GUARD_W)) guard_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (guard_load_i),
    .run_i      (run),
    .limit_en_o (limit_en),
    .expire_o   (expire)
  );

  selftest_fsm #(.RST_CYCLES(RST_CYCLES)) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .logic_done_i (logic_done_i),
    .logic_fail_i (logic_fail_i),
    .mem_done_i   (mem_done_i),
    .mem_fail_i   (mem_fail_i),
    .expire_i     (expire),
    .load_o       (load),
    .run_o        (run),
    .phase_o      (phase),
    .evt_o        (evt)
  );

  selftest_flags flags_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .evt_i       (evt),
    .logic_end_o (logic_end_o),
    .mem_end_o   (mem_end_o),
    .logic_bad_o (logic_bad_o),
    .mem_bad_o   (mem_bad_o),
    .guard_to_o  (guard_to_o),
    .any_fail_o  (any_fail_o)
  );

  assign logic_req_o = (phase == PH_LOGIC);
  assign mem_req_o   = (phase == PH_MEM);
  assign reset_req_o = (phase == PH_RESET);
  assign busy_o      = (phase != PH_IDLE);
endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic clear_i,
  input logic logic_req_o,
  input logic mem_req_o,
  input logic busy_o,
  input logic logic_end_o,
  input logic mem_end_o,
  input logic guard_to_o,
  input logic any_fail_o,
  input logic reset_req_o,
  input logic limit_en
);
  p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(logic_req_o && mem_req_o));

  p_mem_after_logic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o) |-> logic_end_o && $past(logic_req_o));

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> logic_req_o);

  p_expire_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard_to_o) |-> reset_req_o && !logic_req_o && !mem_req_o && any_fail_o);

  p_no_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard_to_o) |-> limit_en);

  p_reset_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req_o) |=> reset_req_o ##1 reset_req_o ##1 reset_req_o ##1 !reset_req_o);

  p_end_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    logic_end_o && !clear_i |=> logic_end_o);

  p_to_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    guard_to_o && !clear_i |=> guard_to_o);

  p_mem_end_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_end_o) |-> $past(mem_req_o));
endmodule

bind selftest_seq selftest_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .clear_i     (clear_i),
  .logic_req_o (logic_req_o),
  .mem_req_o   (mem_req_o),
  .busy_o      (busy_o),
  .logic_end_o (logic_end_o),
  .mem_end_o   (mem_end_o),
  .guard_to_o  (guard_to_o),
  .any_fail_o  (any_fail_o),
  .reset_req_o (reset_req_o),
  .limit_en    (limit_en)
);

// File: tb/selftest_seq_tb_top.sv
module selftest_seq_tb_top;
  localparam int GW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, clear_i = 1'b0;
  logic [GW-1:0] guard_load_i = '0;
  logic logic_done_i = 1'b0, logic_fail_i = 1'b0, mem_done_i = 1'b0, mem_fail_i = 1'b0;
  logic logic_req_o, mem_req_o, busy_o, logic_end_o, mem_end_o;
  logic logic_bad_o, mem_bad_o, guard_to_o, any_fail_o, reset_req_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  selftest_seq #(.GUARD_W(GW), .RST_CYCLES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .guard_load_i(guard_load_i), .logic_done_i(logic_done_i),
    .logic_fail_i(logic_fail_i), .mem_done_i(mem_done_i), .mem_fail_i(mem_fail_i),
    .logic_req_o(logic_req_o), .mem_req_o(mem_req_o), .busy_o(busy_o),
    .logic_end_o(logic_end_o), .mem_end_o(mem_end_o), .logic_bad_o(logic_bad_o),
    .mem_bad_o(mem_bad_o), .guard_to_o(guard_to_o), .any_fail_o(any_fail_o),
    .reset_req_o(reset_req_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flags packed as {end_l, end_m, bad_l, bad_m, to, fail}
  function automatic int flags();
    return {26'd0, logic_end_o, mem_end_o, logic_bad_o, mem_bad_o, guard_to_o, any_fail_o};
  endfunction

  task automatic do_clear();
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    chk("R10 clear", flags(), 0);
  endtask

  // start a run; returns at the negedge where the first request cycle is visible
  task automatic kick(input int lim);
    guard_load_i = GW'(lim);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R1 logic req", logic_req_o, 1);
    chk("R1 mem req low", mem_req_o, 0);
    chk("R1 busy", busy_o, 1);
  endtask

  // count reset-request cycles from current negedge, then check idle
  task automatic drain_reset(input string req);
    int n = 0;
    while (reset_req_o && n < 20) begin
      n++;
      @(negedge clk);
    end
    chk(req, n, 4);
    chk("R8 idle after reset", busy_o, 0);
  endtask

  // engine gives done on its k-th request cycle (k>=1)
  task automatic engine_logic(input int k, input logic f);
    for (int i = 1; i < k; i++) @(negedge clk);
    logic_done_i = 1'b1; logic_fail_i = f;
    @(negedge clk);
    logic_done_i = 1'b0; logic_fail_i = 1'b0;
  endtask

  task automatic engine_mem(input int k, input logic f);
    for (int i = 1; i < k; i++) @(negedge clk);
    mem_done_i = 1'b1; mem_fail_i = f;
    @(negedge clk);
    mem_done_i = 1'b0; mem_fail_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset flags", flags(), 0);
    chk("R1 reset idle", {logic_req_o, mem_req_o, busy_o, reset_req_o}, 0);
  endtask

  task automatic t_pass();
    do_clear();
    kick(0);
    engine_logic(3, 1'b0);
    chk("R2 logic end", logic_end_o, 1);
    chk("R2 handover", {logic_req_o, mem_req_o}, 1);
    engine_mem(5, 1'b0);
    chk("R3 mem end", mem_end_o, 1);
    chk("R3 reset req", reset_req_o, 1);
    chk("R4 pass flags", flags(), 6'b110000);
    drain_reset("R8 pass reset len");
    repeat (5) @(negedge clk);
    chk("R10 flags kept", flags(), 6'b110000);
  endtask

  task automatic t_fails();
    do_clear();
    kick(0);
    engine_logic(1, 1'b1);
    engine_mem(2, 1'b0);
    chk("R4 logic fail", flags(), 6'b111001);
    drain_reset("R8 fail reset len");
    do_clear();
    kick(0);
    engine_logic(2, 1'b0);
    engine_mem(1, 1'b1);
    chk("R4 mem fail", flags(), 6'b110101);
    drain_reset("R8 mem fail reset len");
  endtask

  task automatic t_to_logic();
    int n = 0;
    do_clear();
    kick(6);
    while (logic_req_o && n < 50) begin n++; @(negedge clk); end
    chk("R5 logic req cycles", n, 6);
    chk("R5 reset after expiry", reset_req_o, 1);
    chk("R6 logic timeout flags", flags(), 6'b000011);
    drain_reset("R8 timeout reset len");
  endtask

  task automatic t_to_mem();
    int n = 0;
    do_clear();
    kick(8);
    engine_logic(3, 1'b0);
    while (mem_req_o && n < 50) begin
      n++;
      if (n == 5) mem_done_i = 1'b1;  // expiry cycle: 3 + 5 = 8
      @(negedge clk);
      mem_done_i = 1'b0;
    end
    chk("R5 mem req cycles", n, 5);
    chk("R6 mem timeout flags", flags(), 6'b100011);
    drain_reset("R8 mem timeout reset len");
  endtask

  task automatic t_coincide();
    do_clear();
    kick(3);
    engine_logic(3, 1'b0);  // done in the expiry cycle
    chk("R5 done discarded", logic_end_o, 0);
    chk("R6 no mem start", mem_req_o, 0);
    chk("R5 coincide to", guard_to_o, 1);
    drain_reset("R8 coincide reset len");
  endtask

  task automatic t_no_limit();
    do_clear();
    kick(0);
    repeat (300) @(negedge clk);
    chk("R7 still running", logic_req_o, 1);
    engine_logic(1, 1'b0);
    repeat (200) @(negedge clk);
    chk("R7 mem still running", mem_req_o, 1);
    engine_mem(1, 1'b0);
    chk("R7 no timeout", flags(), 6'b110000);
    drain_reset("R8 no-limit reset len");
  endtask

  task automatic t_start_ignored();
    int runs = 0;
    do_clear();
    kick(0);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    chk("R9 still logic", logic_req_o, 1);
    engine_logic(1, 1'b0);
    engine_mem(1, 1'b0);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;  // during reset request
    while (busy_o && runs < 20) begin runs++; @(negedge clk); end
    repeat (3) @(negedge clk);
    chk("R9 no second run", busy_o, 0);
    chk("R9 no request", logic_req_o, 0);
  endtask

  task automatic t_stray();
    do_clear();
    logic_done_i = 1'b1; mem_done_i = 1'b1; logic_fail_i = 1'b1; mem_fail_i = 1'b1;
    @(negedge clk);
    logic_done_i = 1'b0; mem_done_i = 1'b0; logic_fail_i = 1'b0; mem_fail_i = 1'b0;
    chk("R11 idle done ignored", flags(), 0);
    chk("R11 idle stays idle", busy_o, 0);
    kick(0);
    engine_mem(1, 1'b1);  // memory done while logic runs
    chk("R11 mem done in logic", {mem_end_o, mem_bad_o, any_fail_o}, 0);
    chk("R11 phase kept", logic_req_o, 1);
    engine_logic(1, 1'b0);
    engine_mem(1, 1'b0);
    drain_reset("R8 stray reset len");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_fails();
    t_to_logic();
    t_to_mem();
    t_coincide();
    t_no_limit();
    t_start_ignored();
    t_stray();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule